// File: doc/BRIEF.md
# Debug Instruction Injection Scan Chain

This block is the data scan register that a debug TAP uses to talk to a halted processor core. Each scan carries a 33-bit word. The low 32 bits are an instruction to feed into the core or a data value taken from its bus. Bit 32 is a speed flag. In Capture-DR the block loads the core bus together with a return flag. In Shift-DR it shifts the word out on `tdo` and in from `tdi`, least significant bit first. In Update-DR it presents the new low 32 bits to the core as the injected instruction. An update arrives after exactly 33 shifts, and each such update gives one pulse of the core's debug clock. A 16-bit compressed instruction may be written twice, once in each half of the 32-bit field. The block passes both halves through unchanged, so the core can read either one.

A small sequencer decides how the next instruction runs. A word scanned with the flag high arms it, and the instruction scanned after that word is the one that runs at system speed. The switch to the system clock waits until the TAP instruction register holds BYPASS. The sequencer then raises a system-speed request. The request stays high until the core has left debug and shown that it is back with both the memory-request-low and debug-acknowledge signals high. The next captured word then carries the flag set. Leaving debug follows a similar pattern. The last flagged word is followed by a branch, and once RESTART is selected, the resume pulse waits until the TAP enters Run-Test/Idle.

Top module: `dbg_inject_chain`

## Requirements
- R1: After reset, `tdo`, `dclk_pulse`, `sys_req` and `resume_pulse` are 0 and `instr_word` is 0.
- R2: While `chain_sel` is high, Capture-DR loads {return flag, `core_bus`} (return flag at bit 32). Each following Shift-DR cycle presents the current bit 0 on `tdo` and shifts `tdi` into bit 32, so the captured word leaves LSB first.
- R3: An Update-DR that follows exactly 33 shifts since the last capture loads bits 31:0 of the shifted-in word onto `instr_word`. In the cycle after the update edge it also raises `dclk_pulse` for exactly one cycle.
- R4: An Update-DR that follows any shift count other than 33 leaves `instr_word` unchanged and gives no `dclk_pulse`.
- R5: `sys_req` rises only when three things hold: the word scanned before the last full update had bit 32 high, no later full update has happened, and `ir_bypass` is high. Words whose bit 32 is low never lead to `sys_req`.
- R6: Once raised, `sys_req` holds. It stays high until the core has shown `core_mreq_n` or `core_dbgack` low and then has both high. It drops on the edge of the cycle in which both are seen high.
- R7: While `sys_req` is high, a full update gives no `dclk_pulse`.
- R8: The first Capture-DR after a system-speed access completes reads bit 32 as 1, and later captures read 0. This also holds when the capture falls in the completion cycle itself.
- R9: With an armed-and-loaded instruction pending and `ir_restart` high, `resume_pulse` stays low until `run_idle` is high. It then pulses for one cycle, and the pending state is consumed.
- R10: `sys_done` equals `core_mreq_n` AND `core_dbgack` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock |
| trst_n | input | 1 | Active-low reset |
| chain_sel | input | 1 | This chain is selected by the TAP instruction |
| capture_dr | input | 1 | TAP in Capture-DR |
| shift_dr | input | 1 | TAP in Shift-DR |
| update_dr | input | 1 | TAP in Update-DR |
| run_idle | input | 1 | TAP in Run-Test/Idle |
| ir_bypass | input | 1 | TAP instruction register holds BYPASS |
| ir_restart | input | 1 | TAP instruction register holds RESTART |
| tdi | input | 1 | Serial data in |
| core_bus | input | 32 | Core data bus sampled at capture |
| core_mreq_n | input | 1 | Core memory request, active low |
| core_dbgack | input | 1 | Core debug acknowledge |
| tdo | output | 1 | Serial data out |
| instr_word | output | 32 | Instruction presented to the core |
| dclk_pulse | output | 1 | One-cycle core debug clock |
| sys_req | output | 1 | System-speed execution request |
| resume_pulse | output | 1 | Restart to system clock |
| sys_done | output | 1 | System-speed access completion status |

## Verification
Two events can fall in the same cycle: the completion of a system-speed access and a Capture-DR. If the capture read only the stored return flag, it would miss the completion and lose the flag. The bench raises `capture_dr` in exactly the cycle where the core first shows both status inputs high after dropping them. It then shifts the word out and expects bit 32 to be 1. The capture after that must read 0. A second overlap is also exercised: a full update arriving while `sys_req` is outstanding, which must not clock the core.

// File: rtl/dbg_inject_pkg.sv
package dbg_inject_pkg;
    localparam int WORD_W = 32;
    localparam int CHAIN_W = WORD_W + 1;

    typedef struct packed {
        logic arm;      // last full word carried the flag
        logic pend;     // instruction loaded that runs at system speed / restart
        logic req;      // system-speed request outstanding
        logic started;  // core has left debug during the request
        logic ret;      // return flag for the next capture
        logic dclk;     // debug clock pulse
        logic resume;   // restart pulse
    } seq_state_t;
endpackage

// File: rtl/dbg_scan_shift.sv
module dbg_scan_shift #(
    parameter int LEN = 33
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel,
    input  logic           cap,
    input  logic           shift,
    input  logic           upd,
    input  logic           tdi,
    input  logic [LEN-1:0] cap_word,
    output logic           tdo,
    output logic [LEN-2:0] word_out,
    output logic           upd_full,
    output logic           upd_flag
);
    localparam int CW = $clog2(LEN + 2);
    localparam logic [CW-1:0] FULL = CW'(LEN);
    localparam logic [CW-1:0] OVER = CW'(LEN + 1);

    typedef struct packed {
        logic [LEN-1:0] sh;
        logic [LEN-2:0] par;
        logic [CW-1:0]  cnt;
    } scan_state_t;

    scan_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sel && cap) begin
            s_d.sh  = cap_word;
            s_d.cnt = '0;
        end else if (sel && shift) begin
            s_d.sh = {tdi, s_q.sh[LEN-1:1]};
            if (s_q.cnt != OVER) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (sel && upd) begin
            if (s_q.cnt == FULL) begin
                s_d.par = s_q.sh[LEN-2:0];
            end
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tdo      = s_q.sh[0];
    assign word_out = s_q.par;
    assign upd_full = sel && upd && (s_q.cnt == FULL);
    assign upd_flag = s_q.sh[LEN-1];

    p_short_scan_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && upd && !cap && !shift && s_q.cnt != FULL) |=> $stable(word_out));
endmodule

// File: rtl/dbg_speed_seq.sv
module dbg_speed_seq
    import dbg_inject_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_full,
    input  logic upd_flag,
    input  logic cap_evt,
    input  logic ir_bypass,
    input  logic ir_restart,
    input  logic run_idle,
    input  logic mreq_n,
    input  logic dbgack,
    output logic cap_flag,
    output logic dclk,
    output logic req,
    output logic resume
);
    seq_state_t s_d, s_q;
    logic done_now;

    always_comb begin
        done_now = s_q.req && s_q.started && mreq_n && dbgack;
        s_d = s_q;
        s_d.dclk = 1'b0;
        s_d.resume = 1'b0;

        if (s_q.req) begin
            if (!mreq_n || !dbgack) begin
                s_d.started = 1'b1;
            end
            if (done_now) begin
                s_d.req = 1'b0;
                s_d.started = 1'b0;
            end
        end

        if (cap_evt) begin
            s_d.ret = 1'b0;
        end else if (done_now) begin
            s_d.ret = 1'b1;
        end

        if (upd_full && !s_q.req) begin
            s_d.dclk = 1'b1;
            s_d.pend = s_q.arm;
            s_d.arm  = upd_flag;
        end else if (s_q.pend && !s_q.req) begin
            if (ir_bypass) begin
                s_d.req  = 1'b1;
                s_d.pend = 1'b0;
            end else if (ir_restart && run_idle) begin
                s_d.resume = 1'b1;
                s_d.pend   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cap_flag = s_q.ret || done_now;
    assign dclk     = s_q.dclk;
    assign req      = s_q.req;
    assign resume   = s_q.resume;

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.req && !(mreq_n && dbgack)) |=> s_q.req);
    p_req_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.req) |-> $past(ir_bypass));
    p_resume_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.resume |-> $past(run_idle && ir_restart));
    p_ret_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ret) |-> $past(s_q.req));
endmodule

// File: rtl/dbg_inject_chain.sv
module dbg_inject_chain
    import dbg_inject_pkg::*;
(
    input  logic              tck,
    input  logic              trst_n,
    input  logic              chain_sel,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              run_idle,
    input  logic              ir_bypass,
    input  logic              ir_restart,
    input  logic              tdi,
    input  logic [WORD_W-1:0] core_bus,
    input  logic              core_mreq_n,
    input  logic              core_dbgack,
    output logic              tdo,
    output logic [WORD_W-1:0] instr_word,
    output logic              dclk_pulse,
    output logic              sys_req,
    output logic              resume_pulse,
    output logic              sys_done
);
    logic upd_full, upd_flag, cap_flag;

    dbg_scan_shift #(.LEN(CHAIN_W)) u_shift (
        .clk      (tck),
        .rst_n    (trst_n),
        .sel      (chain_sel),
        .cap      (capture_dr),
        .shift    (shift_dr),
        .upd      (update_dr),
        .tdi      (tdi),
        .cap_word ({cap_flag, core_bus}),
        .tdo      (tdo),
        .word_out (instr_word),
        .upd_full (upd_full),
        .upd_flag (upd_flag)
    );

    dbg_speed_seq u_seq (
        .clk        (tck),
        .rst_n      (trst_n),
        .upd_full   (upd_full),
        .upd_flag   (upd_flag),
        .cap_evt    (chain_sel && capture_dr),
        .ir_bypass  (ir_bypass),
        .ir_restart (ir_restart),
        .run_idle   (run_idle),
        .mreq_n     (core_mreq_n),
        .dbgack     (core_dbgack),
        .cap_flag   (cap_flag),
        .dclk       (dclk_pulse),
        .req        (sys_req),
        .resume     (resume_pulse)
    );

    assign sys_done = core_mreq_n && core_dbgack;

    p_dclk_single_r3: assert property (@(posedge tck) disable iff (!trst_n)
        dclk_pulse |=> !dclk_pulse);
    p_no_dclk_req_r7: assert property (@(posedge tck) disable iff (!trst_n)
        sys_req |=> !dclk_pulse);
endmodule

// File: tb/tb_dbg_inject_chain.sv
module tb_dbg_inject_chain;
    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic chain_sel = 1'b1, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
    logic run_idle = 1'b0, ir_bypass = 1'b0, ir_restart = 1'b0, tdi = 1'b0;
    logic [31:0] core_bus = '0;
    logic core_mreq_n = 1'b1, core_dbgack = 1'b1;
    logic tdo, dclk_pulse, sys_req, resume_pulse, sys_done;
    logic [31:0] instr_word;

    int n_vec = 0;
    int n_bad = 0;

    always #4 tck = ~tck;

    dbg_inject_chain dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge tck);
        #2;
    endtask

    task automatic scan(input logic [32:0] w, input logic [31:0] busv, input int n,
                        input bit do_cap, output logic [32:0] got);
        got = '0;
        if (do_cap) begin
            core_bus = busv; capture_dr = 1'b1;
            cyc();
            capture_dr = 1'b0;
        end
        for (int i = 0; i < n; i++) begin
            shift_dr = 1'b1;
            tdi = (i < 33) ? w[i] : 1'b0;
            if (i < 33) got[i] = tdo;
            cyc();
        end
        shift_dr = 1'b0;
        update_dr = 1'b1;
        cyc();
        update_dr = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [32:0] got;
        logic [31:0] prev;
        cyc(); cyc();
        chk("R1 tdo", 64'(tdo), 0);
        chk("R1 dclk", 64'(dclk_pulse), 0);
        chk("R1 req", 64'(sys_req), 0);
        chk("R1 resume", 64'(resume_pulse), 0);
        chk("R1 instr", 64'(instr_word), 0);
        trst_n = 1'b1;
        cyc();

        // R2/R3 sweep: walking ones and their inverses on data bits
        for (int i = 0; i < 32; i++) begin
            for (int inv = 0; inv < 2; inv++) begin
                logic [31:0] pat;
                pat = 32'h1 << i;
                if (inv == 1) pat = ~pat;
                scan({1'b0, pat}, ~pat ^ 32'h5a5a_a5a5, 33, 1, got);
                chk("R2 captured", 64'(got), 64'({1'b0, ~pat ^ 32'h5a5a_a5a5}));
                chk("R3 instr", 64'(instr_word), 64'(pat));
                chk("R3 dclk", 64'(dclk_pulse), 1);
                cyc();
                chk("R3 dclk one cycle", 64'(dclk_pulse), 0);
            end
        end

        // duplicated halfword passes unchanged (R3)
        scan({1'b0, 32'h4700_4700}, 32'h0, 33, 1, got);
        chk("R3 halfword pair", 64'(instr_word), 64'h4700_4700);
        cyc();

        // R4: short and long scans ignored
        prev = instr_word;
        for (int n = 30; n < 37; n++) begin
            if (n != 33) begin
                scan({1'b0, 32'hdead_beef}, 32'h0, n, 1, got);
                chk("R4 instr unchanged", 64'(instr_word), 64'(prev));
                chk("R4 no dclk", 64'(dclk_pulse), 0);
                cyc();
            end
        end

        // R5 negative: flag-low words never request
        ir_bypass = 1'b1; cyc(); cyc();
        chk("R5 no req without flag", 64'(sys_req), 0);
        ir_bypass = 1'b0;

        // R10: completion status
        for (int k = 0; k < 4; k++) begin
            core_mreq_n = k[0]; core_dbgack = k[1]; #1;
            chk("R10 sys_done", 64'(sys_done), 64'(k == 3));
        end
        core_mreq_n = 1'b1; core_dbgack = 1'b1;

        // R5 positive: flag word then the system-speed instruction
        scan({1'b1, 32'he1a0_0000}, 32'h0, 33, 1, got);
        scan({1'b0, 32'he590_1000}, 32'h0, 33, 1, got);
        cyc();
        chk("R5 no req before bypass", 64'(sys_req), 0);
        ir_bypass = 1'b1; cyc(); ir_bypass = 1'b0;
        chk("R5 req after bypass", 64'(sys_req), 1);
        // R7: full update while request outstanding
        scan({1'b0, 32'h1111_2222}, 32'h0, 33, 1, got);
        chk("R7 no dclk during req", 64'(dclk_pulse), 0);
        cyc();
        // R6: held while status stays high before start
        chk("R6 held", 64'(sys_req), 1);
        core_mreq_n = 1'b0; core_dbgack = 1'b0; cyc();
        chk("R6 held while busy", 64'(sys_req), 1);
        core_dbgack = 1'b1; cyc();
        chk("R6 held mreq low", 64'(sys_req), 1);
        core_mreq_n = 1'b1; cyc();
        chk("R6 dropped on completion", 64'(sys_req), 0);
        scan({1'b0, 32'h0}, 32'hcafe_0001, 33, 1, got);
        chk("R8 flag after return", 64'(got), 64'({1'b1, 32'hcafe_0001}));
        cyc();
        scan({1'b0, 32'h0}, 32'hcafe_0002, 33, 1, got);
        chk("R8 flag cleared", 64'(got), 64'({1'b0, 32'hcafe_0002}));
        cyc();

        // R8: completion and capture in the same cycle
        scan({1'b1, 32'h0}, 32'h0, 33, 1, got);
        scan({1'b0, 32'he590_2000}, 32'h0, 33, 1, got);
        ir_bypass = 1'b1; cyc(); ir_bypass = 1'b0;
        chk("R5 req again", 64'(sys_req), 1);
        core_mreq_n = 1'b0; core_dbgack = 1'b0; cyc();
        core_mreq_n = 1'b1; core_dbgack = 1'b1;
        core_bus = 32'h0bad_f00d; capture_dr = 1'b1;
        cyc();
        capture_dr = 1'b0;
        chk("R6 drop at collision", 64'(sys_req), 0);
        scan({1'b0, 32'h0}, 32'h0, 33, 0, got);
        chk("R8 same-cycle capture", 64'(got), 64'({1'b1, 32'h0bad_f00d}));
        cyc();
        scan({1'b0, 32'h0}, 32'h7, 33, 1, got);
        chk("R8 cleared after collision", 64'(got[32]), 0);
        cyc();

        // R9: restart waits for Run-Test/Idle
        scan({1'b1, 32'he1a0_0000}, 32'h0, 33, 1, got);
        scan({1'b0, 32'hea00_0000}, 32'h0, 33, 1, got);
        ir_restart = 1'b1;
        for (int k = 0; k < 5; k++) begin
            cyc();
            chk("R9 no resume before idle", 64'(resume_pulse), 0);
        end
        run_idle = 1'b1; cyc();
        chk("R9 resume at idle", 64'(resume_pulse), 1);
        cyc();
        chk("R9 single pulse", 64'(resume_pulse), 0);
        run_idle = 1'b0; ir_restart = 1'b0;
        cyc();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule